// File: doc/BRIEF.md
# Restoring Sequential Integer Divider

This block divides an unsigned W-bit dividend by an unsigned W-bit divisor. It produces a W-bit quotient and a W-bit remainder, one quotient bit per clock. A start pulse loads the operands. The block then runs a fixed number of shift-and-trial-subtract steps and raises a done flag that stays high, with the results held, until the next start.

The partial remainder and the dividend sit side by side as one 2W-bit register that shifts left on every step. Each new quotient bit drops into the low end that the shift has just emptied. As a result the quotient ends up in the dividend register, and no separate quotient register exists.

The trial subtraction is one (W+1)-bit subtract. Its borrow decides whether the divisor fits. A small down-counter ends the run after exactly W steps. A zero divisor needs no special handling: every trial "fits", so the quotient comes out all ones and the remainder comes out equal to the dividend.

Top module: `restoring_divider`

## Requirements
- R1: After reset, done_o is 0 and quot_o and rem_o are both zero.
- R2: A start is accepted only while the block is not running, that is, when it is idle or showing a finished result. Operands are captured at the accepting edge. Changes on dividend_i, divisor_i or start while a division runs have no effect on that division.
- R3: If start is sampled at clock edge k, done_o is 0 after edges k+1 through k+W-1 and becomes 1 after edge k+W.
- R4: With a non-zero divisor, the final outputs satisfy quot_o * divisor + rem_o == dividend and rem_o < divisor.
- R5: With a zero divisor, the final quot_o is all ones and the final rem_o equals the dividend.
- R6: Once done_o is 1, done_o, quot_o and rem_o hold their values until a start is accepted.
- R7: In the cycle after a start is accepted, rem_o reads zero (cleared remainder) and quot_o reads the captured dividend.
- R8: After i steps (1 <= i <= W), rem_o equals (dividend >> (W-i)) mod divisor, or dividend >> (W-i) when the divisor is zero. At every step the running remainder stays below a non-zero divisor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted when not running |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| quot_o | output | W | Quotient (shows the shifting dividend/quotient register while running) |
| rem_o | output | W | Remainder (shows the partial remainder while running) |
| done_o | output | 1 | High while a finished result is presented |

## Verification
The checker assumes that start, dividend_i and divisor_i are always known (never X) at the sampling edge. It also assumes that reset is applied before the first start. Its operand copy and step counter rely on these. The bench meets both conditions: it drives every input at the falling clock edge, only with defined values, and holds reset for several cycles first. To show that inputs are ignored while a division runs, the bench deliberately toggles start and scrambles the operand inputs in mid-run.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_trial_sub.sv
// One restoring step: shift in the next dividend bit, trial-subtract the divisor.
module div_trial_sub #(
    parameter int W = 8
) (
    input  logic [W-1:0] rem_i,
    input  logic         next_bit_i,
    input  logic [W-1:0] div_i,
    output logic         fits_o,
    output logic [W-1:0] rem_o
);
    localparam int PW = W + 1;

    logic [PW-1:0] partial;
    logic [PW:0]   diff;
    logic          unused_hi;

    always_comb begin
        partial = {rem_i, next_bit_i};
        diff    = {1'b0, partial} - {2'b00, div_i};
        fits_o  = ~diff[PW];
        // Remainder is always below the divisor, so only W bits survive.
        rem_o   = fits_o ? diff[W-1:0] : partial[W-1:0];
    end

    assign unused_hi = diff[W] ^ partial[W];
endmodule

// File: rtl/div_iter_cnt.sv
// Down-counter tracking the remaining steps; last_o marks the final one.
module div_iter_cnt #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic step_i,
    output logic last_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(W - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = LOAD_VAL;
        end else if (step_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
    import div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         done_o
);
    typedef struct packed {
        div_state_e   st;
        logic [W-1:0] rem;
        logic [W-1:0] quo;
        logic [W-1:0] div;
    } div_regs_t;

    div_regs_t    r_d, r_q;
    logic         busy;
    logic         accept;
    logic         last_step;
    logic         fits;
    logic [W-1:0] rem_step;

    assign busy   = (r_q.st == ST_RUN);
    assign accept = start && !busy;

    div_trial_sub #(.W(W)) u_sub (
        .rem_i      (r_q.rem),
        .next_bit_i (r_q.quo[W-1]),
        .div_i      (r_q.div),
        .fits_o     (fits),
        .rem_o      (rem_step)
    );

    div_iter_cnt #(.W(W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .step_i (busy),
        .last_o (last_step)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_RUN: begin
                r_d.rem = rem_step;
                r_d.quo = {r_q.quo[W-2:0], fits};
                if (last_step) begin
                    r_d.st = ST_FIN;
                end
            end
            default: begin
                if (start) begin
                    r_d.st  = ST_RUN;
                    r_d.rem = '0;
                    r_d.quo = dividend_i;
                    r_d.div = divisor_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, rem: '0, quo: '0, div: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign quot_o = r_q.quo;
    assign rem_o  = r_q.rem;
    assign done_o = (r_q.st == ST_FIN);
endmodule

// File: rtl/divider_chk.sv
module divider_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] dividend_i,
    input logic [W-1:0] divisor_i,
    input logic [W-1:0] quot_o,
    input logic [W-1:0] rem_o,
    input logic         done_o,
    input logic         busy,
    input logic [W-1:0] div_reg
);
    localparam int RW = $clog2(W + 1) + 1;

    logic [W-1:0]   cap_a, cap_b;
    logic [RW-1:0]  run_cnt;
    logic [2*W-1:0] recon;
    logic           acc;

    assign acc   = start && !busy;
    assign recon = ({{W{1'b0}}, quot_o} * {{W{1'b0}}, cap_b}) + {{W{1'b0}}, rem_o};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            run_cnt <= '0;
        end else if (acc) begin
            cap_a   <= dividend_i;
            cap_b   <= divisor_i;
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_DONE_AFTER_W: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (run_cnt == RW'(W))); // R3

    AST_RESULT_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b != '0) |-> (recon == {{W{1'b0}}, cap_a} && rem_o < cap_b)); // R4

    AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cap_b == '0) |-> (quot_o == '1 && rem_o == cap_a)); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start) |=> (done_o && $stable(quot_o) && $stable(rem_o))); // R6

    AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(div_reg)); // R2

    AST_CLEARED_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (rem_o == '0 && busy)); // R7

    AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && div_reg != '0) |-> (rem_o < div_reg)); // R8

    AST_NO_DONE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done_o); // R3
endmodule

bind restoring_divider divider_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .done_o     (done_o),
    .busy       (busy),
    .div_reg    (r_q.div)
);

// File: tb/restoring_divider_tb.sv
module restoring_divider_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic [W-1:0] quot_o, rem_o;
    logic         done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    restoring_divider #(.W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .quot_o     (quot_o),
        .rem_o      (rem_o),
        .done_o     (done_o)
    );

    function automatic logic [W-1:0] exp_q(input logic [W-1:0] a, input logic [W-1:0] b);
        return (b == '0) ? '1 : a / b;
    endfunction

    function automatic logic [W-1:0] exp_r(input logic [W-1:0] a, input logic [W-1:0] b);
        return (b == '0) ? a : a % b;
    endfunction

    function automatic logic [W-1:0] exp_mid(input logic [W-1:0] a, input logic [W-1:0] b, input int i);
        logic [W-1:0] top;
        top = a >> (W - i);
        return (b == '0) ? top : top % b;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit noisy);
        logic [W-1:0] hq, hr;
        @(negedge clk);
        start = 1'b1;
        dividend_i = a;
        divisor_i = b;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R7 remainder cleared", rem_o, '0);
        check("R7 dividend loaded", quot_o, a);
        for (int i = 1; i <= W; i++) begin
            if (noisy) begin
                dividend_i = W'($urandom);
                divisor_i = W'($urandom);
                start = (i < W) ? 1'($urandom) : 1'b0;   // R2: ignored while running
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            check("R8 partial remainder", rem_o, exp_mid(a, b, i));
            check("R3 done timing", {{(W-1){1'b0}}, done_o}, (i == W) ? W'(1) : W'(0));
        end
        check(b == '0 ? "R5 quotient" : "R4 R2 quotient", quot_o, exp_q(a, b));
        check(b == '0 ? "R5 remainder" : "R4 R2 remainder", rem_o, exp_r(a, b));
        hq = quot_o;
        hr = rem_o;
        dividend_i = ~a;
        divisor_i = ~b;
        repeat (2) @(negedge clk);
        check("R6 hold quotient", quot_o, hq);
        check("R6 hold remainder", rem_o, hr);
        check("R6 hold done", {{(W-1){1'b0}}, done_o}, W'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset quotient", quot_o, '0);
        check("R1 reset remainder", rem_o, '0);
        check("R1 reset done", {{(W-1){1'b0}}, done_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle done", {{(W-1){1'b0}}, done_o}, '0);

        run_div(8'd255, 8'd1, 1'b0);
        run_div(8'd255, 8'd255, 1'b0);
        run_div(8'd0, 8'd7, 1'b0);
        run_div(8'd200, 8'd0, 1'b0);
        run_div(8'd0, 8'd0, 1'b0);
        run_div(8'd1, 8'd255, 1'b0);
        run_div(8'd128, 8'd3, 1'b1);
        run_div(8'd254, 8'd17, 1'b1);
        run_div(8'd255, 8'd0, 1'b1);

        for (int k = 0; k < 300; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            case ($urandom % 4)
                0: b = W'($urandom % 4);
                1: b = W'($urandom % 16);
                default: b = W'($urandom);
            endcase
            run_div(a, b, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule